// File: doc/BRIEF.md
# Ternary CAM Packet Flow Classifier

This block sorts packets into flows by looking up a pre-assembled 112-bit search key in a table of ternary entries. The key is built from two parts:

- the fixed IPv4 5-tuple header fields;
- an 8-bit vector that flags which payload content lists the packet matched.

Each table row holds three things:

- a match value;
- a care mask, in which a 1 compares the bit and a 0 ignores it;
- a 16-bit flow identifier.

Every row is compared against the key in parallel. A priority encoder then picks the lowest-numbered matching row, and that row's flow identifier is returned. One identifier value is reserved to mean "discard this packet". When the winning row carries it, a drop flag is raised beside the result.

Software loads rows through a simple write port that carries the row number, value, mask, flow identifier and a row-enable bit. Lookups are fully pipelined: one key can be accepted every cycle, and each result appears exactly two cycles after its key, with its own valid strobe.

Top module: `tcam_flow_classifier`

## Requirements
- R1: The key layout is content vector [111:104], source IPv4 address [103:72], destination IPv4 address [71:40], source port [39:24], destination port [23:8] and protocol [7:0]. Bit i of the content vector means that payload list i matched.
- R2: A row matches when, for every one of the 112 bits where its mask is 1, the key bit equals the value bit. Key bits where the mask is 0 have no effect.
- R3: When several rows match, the result carries the flow identifier of the matching row with the lowest index.
- R4: When no enabled row matches, res_hit is 0, res_flow is 0 and res_drop is 0.
- R5: A key presented with key_valid in cycle t gives res_valid and its result in cycle t+2. A new key may be presented every cycle, and res_valid is 0 two cycles after a cycle with no key.
- R6: A row write (wr_en with wr_idx, wr_value, wr_mask, wr_flow, wr_valid) is seen by lookups presented in later cycles. A lookup presented in the same cycle as the write sees the old row.
- R7: res_drop is 1 exactly when res_hit is 1 and the winning flow identifier is 0xFFFF.
- R8: A row whose enable bit is 0 never matches, and reset clears the enable bit of every row.
- R9: A row may demand only some content bits. For example, content value 0x01 with mask 0x01 matches a key whose content is 0x03, and does not match a key whose content is 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_idx | input | IDX_W (4) | Row number to write |
| wr_value | input | 112 | Match value for the row |
| wr_mask | input | 112 | Care mask for the row (1 = compare) |
| wr_flow | input | 16 | Flow identifier for the row |
| wr_valid | input | 1 | Row enable bit |
| key_valid | input | 1 | Key strobe |
| key | input | 112 | Search key |
| res_valid | output | 1 | Result strobe, two cycles after key_valid |
| res_hit | output | 1 | Some enabled row matched |
| res_flow | output | 16 | Flow identifier of the winning row, 0 on a miss |
| res_drop | output | 1 | Winning row carries the discard identifier 0xFFFF |

## Verification
The hardest situation to reach is a write and a lookup of the same row in the same cycle, where the lookup must still see the old row. The directed phase lines this up on purpose, with the key matching only the new contents. The random phase then keeps issuing writes alongside back-to-back lookups.

A second hard case is several overlapping rows matching at once, which exercises the priority order. To get there, random masks are kept sparse and keys are drawn from a small pool of base headers, so that several rows often match one key.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int KEY_W  = 112;
  localparam int FLOW_W = 16;
  localparam logic [FLOW_W-1:0] FLOW_DISCARD = '1;
endpackage

// File: rtl/tcam_row.sv
module tcam_row
  import tcam_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic              wr_valid,
  input  logic [KEY_W-1:0]  key,
  output logic              match,
  output logic [FLOW_W-1:0] flow
);
  logic [KEY_W-1:0]  row_val;
  logic [KEY_W-1:0]  row_msk;
  logic [FLOW_W-1:0] row_flow;
  logic              row_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_en <= 1'b0;
    end else if (wr_sel) begin
      row_en <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_sel) begin
      row_val  <= wr_value;
      row_msk  <= wr_mask;
      row_flow <= wr_flow;
    end
  end

  assign match = row_en && (((key ^ row_val) & row_msk) == '0);
  assign flow  = row_flow;

  // R8: a disabled row stays silent
  a_r8_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !row_en |-> !match);
  // R6: a write sets the enable bit seen in the next cycle
  a_r6_enable_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> (row_en == $past(wr_valid)));
endmodule

// File: rtl/tcam_prio_sel.sv
module tcam_prio_sel
  import tcam_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]        match,
  input  logic [N*FLOW_W-1:0] flows,
  output logic                hit,
  output logic [FLOW_W-1:0]   flow
);
  always_comb begin
    hit  = 1'b0;
    flow = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        flow = flows[i*FLOW_W +: FLOW_W];
      end
    end
  end
endmodule

// File: rtl/tcam_flow_classifier.sv
module tcam_flow_classifier
  import tcam_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic              wr_valid,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [FLOW_W-1:0] res_flow,
  output logic              res_drop
);
  logic [N-1:0]        row_match;
  logic [N*FLOW_W-1:0] row_flows;
  logic                sel_hit;
  logic [FLOW_W-1:0]   sel_flow;

  for (genvar g = 0; g < N; g++) begin : g_row
    logic sel;
    logic [FLOW_W-1:0] f;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    tcam_row u_row (
      .clk      (clk),
      .rst      (rst),
      .wr_sel   (sel),
      .wr_value (wr_value),
      .wr_mask  (wr_mask),
      .wr_flow  (wr_flow),
      .wr_valid (wr_valid),
      .key      (key),
      .match    (row_match[g]),
      .flow     (f)
    );
    assign row_flows[g*FLOW_W +: FLOW_W] = f;
  end

  tcam_prio_sel #(.N(N)) u_sel (
    .match (row_match),
    .flows (row_flows),
    .hit   (sel_hit),
    .flow  (sel_flow)
  );

  // stage 1: compare, priority pick and flow capture in one cycle
  logic              s1_valid;
  logic              s1_hit;
  logic [FLOW_W-1:0] s1_flow;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_flow  <= '0;
    end else begin
      s1_valid <= key_valid;
      s1_hit   <= sel_hit;
      s1_flow  <= sel_flow;
    end
  end

  // stage 2: discard decode and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_flow  <= '0;
      res_drop  <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      res_hit   <= s1_hit;
      res_flow  <= s1_flow;
      res_drop  <= s1_hit && (s1_flow == FLOW_DISCARD);
    end
  end

  // R5: fixed two-cycle latency
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> ##2 res_valid);
  a_r5_no_phantom: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> ##2 !res_valid);
  // R7: drop only on a hit carrying the discard identifier
  a_r7_drop_flow: assert property (@(posedge clk) disable iff (rst)
    res_drop |-> (res_hit && res_flow == FLOW_DISCARD));
  // R4: a miss returns zero and no drop
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_flow == '0 && !res_drop));
endmodule

// File: tb/tb_tcam_flow_classifier.sv
module tb_tcam_flow_classifier;
  localparam int N = 16;
  localparam int KW = 112;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [KW-1:0] wr_value = '0, wr_mask = '0, key = '0;
  logic [15:0] wr_flow = '0;
  logic wr_valid = 1'b0, key_valid = 1'b0;
  logic res_valid, res_hit, res_drop;
  logic [15:0] res_flow;

  always #5 clk = ~clk;

  tcam_flow_classifier #(.N(N)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_flow(wr_flow),
    .wr_valid(wr_valid), .key_valid(key_valid), .key(key),
    .res_valid(res_valid), .res_hit(res_hit), .res_flow(res_flow),
    .res_drop(res_drop)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [KW-1:0] m_val [N];
  logic [KW-1:0] m_msk [N];
  logic [15:0]   m_flow [N];
  logic          m_en [N];

  // expectations for lookups issued one and two cycles ago
  logic p1_v = 0, p2_v = 0, p1_h = 0, p2_h = 0;
  logic [15:0] p1_f = 0, p2_f = 0;
  string p1_t = "", p2_t = "";

  function automatic logic [KW-1:0] mk_key(logic [7:0] c, logic [31:0] s,
      logic [31:0] d, logic [15:0] sp, logic [15:0] dp, logic [7:0] pr);
    return {c, s, d, sp, dp, pr};  // R1 layout
  endfunction

  function automatic logic [KW-1:0] rnd112();
    return {$urandom(), $urandom(), $urandom(), 16'($urandom())};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [KW-1:0] k, output logic h, output logic [15:0] f);
    h = 0; f = 0;
    for (int i = 0; i < N; i++)
      if (!h && m_en[i] && (((k ^ m_val[i]) & m_msk[i]) == '0)) begin
        h = 1; f = m_flow[i];
      end
  endtask

  // one cycle: check the result due now, then drive this cycle's inputs
  task automatic cyc(logic we, int idx, logic [KW-1:0] v, logic [KW-1:0] m,
      logic [15:0] f, logic en, logic kv, logic [KW-1:0] k, string tag);
    logic eh;
    logic [15:0] ef;
    @(negedge clk);
    chk("R5 valid", 32'(res_valid), 32'(p2_v));
    if (p2_v) begin
      chk({p2_t, " hit"}, 32'(res_hit), 32'(p2_h));
      chk({p2_t, " flow"}, 32'(res_flow), 32'(p2_f));
      chk("R7 drop", 32'(res_drop), 32'(p2_h && p2_f == 16'hFFFF));
    end
    model(k, eh, ef);
    p2_v = p1_v; p2_h = p1_h; p2_f = p1_f; p2_t = p1_t;
    p1_v = kv; p1_h = eh; p1_f = ef; p1_t = tag;
    wr_en = we; wr_idx = 4'(idx); wr_value = v; wr_mask = m; wr_flow = f;
    wr_valid = en; key_valid = kv; key = k;
    if (we) begin
      m_val[idx] = v; m_msk[idx] = m; m_flow[idx] = f; m_en[idx] = en;
    end
  endtask

  task automatic look(logic [KW-1:0] k, string tag);
    cyc(0, 0, '0, '0, 0, 0, 1, k, tag);
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, 0, 0, 0, '0, "R5");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] pkt, filt_v, filt_m, pool [4];
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_flow[i] = '0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R5 reset valid", 32'(res_valid), 0);
    chk("R4 reset hit", 32'(res_hit), 0);
    rst = 1'b0;

    pkt    = mk_key(8'h03, 32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06);
    filt_v = mk_key(8'h01, 32'h80FC0000, 32'h8D8E0000, 16'h0000, 16'h0050, 8'h06);
    filt_m = mk_key(8'h01, 32'hFFFF0000, 32'hFFFF0000, 16'h0000, 16'hFFFF, 8'hFF);

    look(pkt, "R8 empty table");
    // write and lookup in the same cycle: old (empty) row seen
    cyc(1, 5, filt_v, filt_m, 16'hFFFF, 1, 1, pkt, "R6 same-cycle");
    look(pkt, "R2 R9 R1 filter hit");
    look(mk_key(8'h02, 32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06), "R9 content miss");
    look(mk_key(8'h03, 32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06), "R1 src miss");
    look(mk_key(8'h01, 32'h80FC1234, 32'h8D8E9999, 16'hABCD, 16'h0050, 8'h06), "R2 dont-care");
    cyc(1, 2, '0, '0, 16'h1234, 1, 1, pkt, "R6 before catch-all");
    look(pkt, "R3 lower index wins");
    cyc(1, 2, '0, '0, 16'h1234, 0, 1, pkt, "R3 before disable");
    look(pkt, "R8 disabled row");
    look(mk_key(8'h00, 32'h0, 32'h0, 16'h0, 16'h0, 8'h11), "R4 miss");
    idle(); idle(); idle();

    for (int i = 0; i < 4; i++) pool[i] = rnd112();
    for (int c = 0; c < 4000; c++) begin
      logic [KW-1:0] k, m;
      logic we;
      int sel;
      k = pool[$urandom_range(3)] ^ (rnd112() & rnd112() & rnd112() & rnd112());
      we = ($urandom_range(7) == 0);
      sel = $urandom_range(N - 1);
      m = rnd112() & rnd112() & rnd112();
      cyc(we, sel, pool[$urandom_range(3)], m,
          ($urandom_range(5) == 0) ? 16'hFFFF : 16'($urandom()),
          ($urandom_range(9) != 0), ($urandom_range(9) != 0), k, "R2 R3 random");
    end
    idle(); idle(); idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule